// File: doc/BRIEF.md
# Symmetric Decimate-by-Two FIR with Table-Based Arithmetic

This block is the droop-correcting low-pass stage that follows an integrator-comb decimator in a receive chain. It takes one signed sample per accepted handshake, keeps every second output of a 16-tap linear-phase filter, and produces nothing for the outputs that decimation would throw away. No multiplier is used. The taps are symmetric, so the two samples that share a coefficient are added first, leaving eight sums to weight.

The eight sums are weighted by bit-slice lookup. For one bit position, the bits of sums 0 to 3 form one 4-bit address and the bits of sums 4 to 7 form another. Each address selects a precomputed sum of coefficients from its own 16-entry table. Several bit positions are resolved in one clock, shifted into place and accumulated, and the sign bit of each sum is given negative weight. The result is rounded, clipped to the output width and presented with a one-clock valid strobe.

The upstream side sees `in_ready`. With the default of nine bit positions per clock, a result needs two processing clocks, so a sample may arrive on every clock and `in_ready` never drops. With fewer bit positions per clock, `in_ready` drops only when the sample that would start a new result arrives while the previous result is still before its last processing clock.

Top module: `sym_da_decim_fir`

## Requirements
- R1: While `rst` is high, and on the first clock after it falls, `out_valid` is 0, `out_data` is 0 and `in_ready` is 1. A result still being computed when reset arrives is discarded.
- R2: A sample is accepted on a rising edge where `in_valid` and `in_ready` are both 1. Clocks with `in_valid` low change nothing. Accepted samples are counted from reset, starting at 0. Only odd-numbered accepted samples start an output, so exactly one output is produced per two accepted samples.
- R3: The output started by accepted sample n equals the sum over i = 0..15 of h[i]·x[n−i]. The taps satisfy h[i] = h[15−i], and h[0..7] = −75, 150, −300, 600, −1200, 2600, 6501, 9000 as Q1.15 values. Samples before the first one after reset count as zero. The result is scaled by 2^−15 and then rounded per R8 and clipped per R5.
- R4: `out_valid` goes high for exactly one clock. It does so on the second rising edge after the edge that accepts the odd-numbered sample.
- R5: Results above 32767 are output as 32767 and results below −32768 are output as −32768.
- R6: With the default parameters, `in_ready` stays 1 on every clock, including when a sample arrives on every clock.
- R7: `out_data` holds its last value on every clock where `out_valid` is 0.
- R8: Rounding adds one half LSB before truncation, so exact halves go toward positive infinity (3250.5 → 3251, −37.5 → −37).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Sample offered |
| in_ready | output | 1 | Block can take the offered sample |
| in_data | input | 16 | Signed input sample |
| out_valid | output | 1 | One-clock strobe marking a new result |
| out_data | output | 16 | Signed rounded, clipped result |

## Verification
The bench uses the default build: 16 taps, decimation by two, and nine bit positions per processing clock, which gives two processing clocks per output. Samples can therefore arrive back to back, and each new result starts on the same clock the previous one finishes. This exercises the full-rate `in_ready` behaviour and the overlap of one computation's last pass with the next one's start. The default coefficients include odd values and a DC gain above one. An impulse of 16384 therefore produces exact half-LSB results that test rounding, and full-scale inputs of either sign drive the output into clipping.

// File: rtl/sym_da_pkg.sv
package sym_da_pkg;
    localparam int DEF_DATA_W    = 16;
    localparam int DEF_NTAP      = 16;
    localparam int DEF_DEC       = 2;
    localparam int DEF_COEF_W    = 16;
    localparam int DEF_COEF_FRAC = 15;
    localparam int DEF_BPP       = 9;   // bit positions resolved per processing clock
    localparam int DA_GRP        = 4;   // pair sums feeding one lookup table

    // half of the symmetric impulse response, outermost tap at index 0
    localparam logic [DEF_NTAP/2-1:0][DEF_COEF_W-1:0] DEF_COEF = {
        16'sd9000, 16'sd6501, 16'sd2600, -16'sd1200,
        16'sd600,  -16'sd300, 16'sd150,  -16'sd75
    };
endpackage

// File: rtl/sfir_tapline.sv
module sfir_tapline #(
    parameter int DATA_W = 16,
    parameter int NTAP   = 16,
    localparam int NPAIR = NTAP / 2,
    localparam int SUM_W = DATA_W + 1
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             shift,
    input  logic [DATA_W-1:0]                din,
    output logic [NPAIR-1:0][SUM_W-1:0]      pair_sum
);
    logic [NTAP-2:0][DATA_W-1:0] line_d, line_q;
    logic [NTAP-1:0][DATA_W-1:0] view;

    // view[0] is the sample being offered, view[i] the one i samples older
    always_comb begin
        view[0] = din;
        for (int i = 1; i < NTAP; i++) begin
            view[i] = line_q[i-1];
        end
    end

    always_comb begin
        line_d = line_q;
        if (shift) begin
            for (int i = 0; i < NTAP - 1; i++) begin
                line_d[i] = view[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) line_q <= '0;
        else     line_q <= line_d;
    end

    // mirrored taps share a coefficient: add them before any weighting
    always_comb begin
        for (int k = 0; k < NPAIR; k++) begin
            pair_sum[k] = SUM_W'($signed(view[k])) + SUM_W'($signed(view[NTAP-1-k]));
        end
    end
endmodule

// File: rtl/sfir_da_rom.sv
module sfir_da_rom #(
    parameter int NPAIR  = 8,
    parameter int COEF_W = 16,
    parameter int GRP    = 4,
    parameter int BASE   = 0,
    parameter logic [NPAIR-1:0][COEF_W-1:0] COEF = '0,
    localparam int TAB_W = COEF_W + $clog2(GRP),
    localparam int ROM_N = 2 ** GRP
) (
    input  logic [GRP-1:0]   addr,
    output logic [TAB_W-1:0] val
);
    function automatic logic signed [TAB_W-1:0] entry_val(int e);
        logic signed [TAB_W-1:0] a;
        a = '0;
        for (int i = 0; i < GRP; i++) begin
            if (e[i]) a = a + TAB_W'($signed(COEF[BASE+i]));
        end
        return a;
    endfunction

    logic [ROM_N-1:0][TAB_W-1:0] rom;

    for (genvar e = 0; e < ROM_N; e++) begin : g_ent
        localparam logic signed [TAB_W-1:0] ENT = entry_val(e);
        assign rom[e] = ENT;
    end

    assign val = rom[addr];
endmodule

// File: rtl/sfir_da_pass.sv
module sfir_da_pass #(
    parameter int NPAIR  = 8,
    parameter int PAD_W  = 18,
    parameter int BPP    = 9,
    parameter int COEF_W = 16,
    parameter int GRP    = 4,
    parameter int PASS_W = 1,
    parameter logic [NPAIR-1:0][COEF_W-1:0] COEF = '0,
    localparam int NGRP   = NPAIR / GRP,
    localparam int TAB_W  = COEF_W + $clog2(GRP),
    localparam int SL_W   = TAB_W + $clog2(NGRP) + 1,
    localparam int PART_W = SL_W + BPP + 1,
    localparam int IDX_W  = (PAD_W > 1) ? $clog2(PAD_W) : 1
) (
    input  logic [NPAIR-1:0][PAD_W-1:0] sums,
    input  logic [PASS_W-1:0]           pass_idx,
    output logic signed [PART_W-1:0]    partial
);
    logic [BPP-1:0][SL_W-1:0] slice_v;

    for (genvar b = 0; b < BPP; b++) begin : g_bit
        logic [IDX_W-1:0]             bidx;
        logic [NGRP-1:0][GRP-1:0]     addr;
        logic [NGRP-1:0][TAB_W-1:0]   rv;
        logic signed [SL_W-1:0]       slice;

        assign bidx = IDX_W'(int'(pass_idx) * BPP + b);

        always_comb begin
            for (int g = 0; g < NGRP; g++) begin
                for (int i = 0; i < GRP; i++) begin
                    addr[g][i] = sums[g*GRP+i][bidx];
                end
            end
        end

        for (genvar g = 0; g < NGRP; g++) begin : g_tab
            sfir_da_rom #(
                .NPAIR (NPAIR),
                .COEF_W(COEF_W),
                .GRP   (GRP),
                .BASE  (g * GRP),
                .COEF  (COEF)
            ) u_rom (
                .addr(addr[g]),
                .val (rv[g])
            );
        end

        // the padded top bit is the two's complement sign: negative weight
        always_comb begin
            slice = '0;
            for (int g = 0; g < NGRP; g++) begin
                slice = slice + SL_W'($signed(rv[g]));
            end
            if (bidx == IDX_W'(PAD_W - 1)) slice = -slice;
        end

        assign slice_v[b] = slice;
    end

    always_comb begin
        partial = '0;
        for (int b = 0; b < BPP; b++) begin
            partial = partial + (PART_W'($signed(slice_v[b])) <<< b);
        end
    end
endmodule

// File: rtl/sym_da_decim_fir.sv
module sym_da_decim_fir
    import sym_da_pkg::*;
#(
    parameter int DATA_W    = DEF_DATA_W,
    parameter int NTAP      = DEF_NTAP,
    parameter int DEC       = DEF_DEC,
    parameter int COEF_W    = DEF_COEF_W,
    parameter int COEF_FRAC = DEF_COEF_FRAC,
    parameter int BPP       = DEF_BPP,
    parameter logic [NTAP/2-1:0][COEF_W-1:0] COEF = DEF_COEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data
);
    localparam int NPAIR  = NTAP / 2;
    localparam int SUM_W  = DATA_W + 1;
    localparam int NPASS  = (SUM_W + BPP - 1) / BPP;
    localparam int PAD_W  = NPASS * BPP;
    localparam int PASS_W = (NPASS > 1) ? $clog2(NPASS) : 1;
    localparam int PH_W   = (DEC > 1) ? $clog2(DEC) : 1;
    localparam int NGRP   = NPAIR / DA_GRP;
    localparam int TAB_W  = COEF_W + $clog2(DA_GRP);
    localparam int SL_W   = TAB_W + $clog2(NGRP) + 1;
    localparam int PART_W = SL_W + BPP + 1;
    localparam int ACC_W  = COEF_W + SUM_W + $clog2(NPAIR) + 3;

    localparam logic signed [ACC_W-1:0] RND_HALF = ACC_W'(1) << (COEF_FRAC - 1);
    localparam logic signed [ACC_W-1:0] OUT_MAX  = (ACC_W'(1) << (DATA_W - 1)) - ACC_W'(1);
    localparam logic signed [ACC_W-1:0] OUT_MIN  = -OUT_MAX - ACC_W'(1);

    typedef struct packed {
        logic [PH_W-1:0]                phase;
        logic                           busy;
        logic [PASS_W-1:0]              pass;
        logic [NPAIR-1:0][PAD_W-1:0]    sums;
        logic signed [ACC_W-1:0]        acc;
        logic [DATA_W-1:0]              out_data;
        logic                           out_valid;
    } fir_state_t;

    fir_state_t st_d, st_q;

    logic                          accept, start, last_pass;
    logic [NPAIR-1:0][SUM_W-1:0]   pair_sum;
    logic signed [PART_W-1:0]      partial;
    logic signed [ACC_W-1:0]       acc_sum, rounded;

    assign last_pass = (st_q.pass == PASS_W'(NPASS - 1));
    assign in_ready  = !st_q.busy || last_pass || (st_q.phase != PH_W'(DEC - 1));
    assign accept    = in_valid && in_ready;
    assign start     = accept && (st_q.phase == PH_W'(DEC - 1));

    sfir_tapline #(
        .DATA_W(DATA_W),
        .NTAP  (NTAP)
    ) u_tapline (
        .clk     (clk),
        .rst     (rst),
        .shift   (accept),
        .din     (in_data),
        .pair_sum(pair_sum)
    );

    sfir_da_pass #(
        .NPAIR (NPAIR),
        .PAD_W (PAD_W),
        .BPP   (BPP),
        .COEF_W(COEF_W),
        .GRP   (DA_GRP),
        .PASS_W(PASS_W),
        .COEF  (COEF)
    ) u_pass (
        .sums    (st_q.sums),
        .pass_idx(st_q.pass),
        .partial (partial)
    );

    always_comb begin
        st_d           = st_q;
        st_d.out_valid = 1'b0;

        acc_sum = st_q.acc + (ACC_W'(partial) <<< (int'(st_q.pass) * BPP));
        rounded = (acc_sum + RND_HALF) >>> COEF_FRAC;

        if (accept) begin
            st_d.phase = (st_q.phase == PH_W'(DEC - 1)) ? '0 : st_q.phase + PH_W'(1);
        end

        if (st_q.busy) begin
            if (last_pass) begin
                st_d.busy      = 1'b0;
                st_d.out_valid = 1'b1;
                if (rounded > OUT_MAX)      st_d.out_data = OUT_MAX[DATA_W-1:0];
                else if (rounded < OUT_MIN) st_d.out_data = OUT_MIN[DATA_W-1:0];
                else                        st_d.out_data = rounded[DATA_W-1:0];
            end else begin
                st_d.pass = st_q.pass + PASS_W'(1);
                st_d.acc  = acc_sum;
            end
        end

        // snapshot the pair sums so the tap line may keep moving
        if (start) begin
            st_d.busy = 1'b1;
            st_d.pass = '0;
            st_d.acc  = '0;
            for (int k = 0; k < NPAIR; k++) begin
                st_d.sums[k] = PAD_W'($signed(pair_sum[k]));
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign out_valid = st_q.out_valid;
    assign out_data  = st_q.out_data;
endmodule

// File: rtl/sym_da_decim_fir_chk.sv
module sym_da_decim_fir_chk #(
    parameter int DATA_W = 16,
    parameter int DEC    = 2,
    parameter int BPP    = 9,
    localparam int NPASS = (DATA_W + 1 + BPP - 1) / BPP,
    localparam int CNT_W = $clog2(NPASS + 1) + 1,
    localparam int PH_W  = (DEC > 1) ? $clog2(DEC) : 1
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              in_ready,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_data
);
    logic [PH_W-1:0]  ph_q;
    logic [CNT_W-1:0] cnt_q;
    logic             fire_q;
    logic             kept;

    assign kept = in_valid && in_ready && (ph_q == PH_W'(DEC - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q   <= '0;
            cnt_q  <= '0;
            fire_q <= 1'b0;
        end else begin
            fire_q <= (cnt_q == CNT_W'(1));
            if (in_valid && in_ready) begin
                ph_q <= (ph_q == PH_W'(DEC - 1)) ? '0 : ph_q + PH_W'(1);
            end
            if (kept)                 cnt_q <= CNT_W'(NPASS);
            else if (cnt_q != '0)     cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    // R1: reset clears the output strobe and leaves the input open
    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (!out_valid && in_ready));

    // R4: strobe lasts one clock
    a_r4_single_strobe: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);

    // R4 and R2: strobe appears exactly NPASS edges after each odd accepted sample
    a_r4_latency: assert property (@(posedge clk) disable iff (rst)
        out_valid == fire_q);

    // R7: data holds between strobes
    a_r7_hold_output: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> $stable(out_data));

    // R6: full input rate when a result needs no more clocks than samples
    if (NPASS <= DEC) begin : g_full_rate
        a_r6_full_rate: assert property (@(posedge clk) disable iff (rst)
            in_ready);
    end
endmodule

bind sym_da_decim_fir sym_da_decim_fir_chk #(
    .DATA_W(DATA_W),
    .DEC   (DEC),
    .BPP   (BPP)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .out_valid(out_valid),
    .out_data (out_data)
);

// File: tb/sym_da_decim_fir_tb.sv
module sym_da_decim_fir_tb;
    localparam int NPASS = 2;
    localparam int QN    = 128;

    // {valid, sample}
    localparam logic [16:0] VEC [24] = '{
        {1'b1, 16'h03E8}, {1'b1, 16'hF830}, {1'b1, 16'h7FFF}, {1'b0, 16'h1234},
        {1'b1, 16'h8000}, {1'b1, 16'h007B}, {1'b0, 16'h7FFF}, {1'b1, 16'h1194},
        {1'b1, 16'hFFF9}, {1'b1, 16'h7530}, {1'b0, 16'h0000}, {1'b0, 16'h8000},
        {1'b1, 16'h8AD0}, {1'b1, 16'h0100}, {1'b1, 16'h0000}, {1'b1, 16'h3A98},
        {1'b1, 16'hC568}, {1'b0, 16'h5555}, {1'b1, 16'h7FFF}, {1'b1, 16'h7FFF},
        {1'b1, 16'hFFFF}, {1'b1, 16'h1FFF}, {1'b1, 16'hE000}, {1'b1, 16'h0005}
    };

    localparam int HHALF [8] = '{-75, 150, -300, 600, -1200, 2600, 6501, 9000};

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [15:0] in_data = '0;
    logic        out_valid;
    logic [15:0] out_data;

    int nchk = 0;
    int nfail = 0;
    int cyc = 0;
    int ready_miss = 0;
    bit done = 0;

    int    hist [16];
    int    ph;
    int    exp_val [QN];
    int    exp_cyc [QN];
    string exp_tag [QN];
    int    head = 0;
    int    tail = 0;
    int    last_exp = 0;
    string cur_tag = "R3";

    sym_da_decim_fir u_dut (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_ready (in_ready),
        .in_data  (in_data),
        .out_valid(out_valid),
        .out_data (out_data)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic model_push(input logic signed [15:0] x);
        longint y;
        longint r;
        for (int i = 15; i > 0; i--) hist[i] = hist[i-1];
        hist[0] = int'(x);
        if (ph == 1) begin
            y = 0;
            for (int i = 0; i < 16; i++) begin
                y += longint'(HHALF[(i < 8) ? i : 15 - i]) * longint'(hist[i]);
            end
            r = (y + 16384) >>> 15;
            if (r > 32767) r = 32767;
            if (r < -32768) r = -32768;
            exp_val[tail % QN] = int'(r);
            exp_cyc[tail % QN] = cyc + 1 + NPASS;
            exp_tag[tail % QN] = cur_tag;
            tail++;
            last_exp = int'(r);
        end
        ph = (ph + 1) % 2;
    endtask

    task automatic send(input logic [15:0] x);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = x;
        while (!in_ready) begin
            ready_miss++;
            @(negedge clk);
        end
        model_push(x);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_data  = 16'hA5A5;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        in_valid = 1'b0;
        repeat (2) @(negedge clk);
        for (int i = 0; i < 16; i++) hist[i] = 0;
        ph = 0;
        head = 0;
        tail = 0;
        last_exp = 0;
        rst = 1'b0;
    endtask

    // output monitor: every strobe must match the next expected result and cycle
    always @(negedge clk) begin
        if (!rst) begin
            if (head != tail && cyc > exp_cyc[head % QN]) begin
                check(1'b0, "R4 missing output", cyc, exp_cyc[head % QN]);
                head++;
            end
            if (out_valid) begin
                if (head != tail && exp_cyc[head % QN] == cyc) begin
                    check($signed(out_data) == exp_val[head % QN], exp_tag[head % QN],
                          $signed(out_data), exp_val[head % QN]);
                    head++;
                end else begin
                    check(1'b0, "R2/R4 unexpected output", cyc, (head != tail) ? exp_cyc[head % QN] : -1);
                end
            end
        end
    end

    task automatic summary();
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
    endtask

    initial begin
        for (int i = 0; i < 200000; i++) @(posedge clk);
        if (!done) begin
            check(1'b0, "watchdog", cyc, 0);
            summary();
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) hist[i] = 0;
        ph = 0;
        repeat (3) @(negedge clk);
        // R1: state during reset
        check(out_valid == 1'b0, "R1 out_valid in reset", out_valid, 0);
        check(out_data == 16'd0, "R1 out_data in reset", out_data, 0);
        check(in_ready == 1'b1, "R1 in_ready in reset", in_ready, 1);
        @(negedge clk);
        rst = 1'b0;

        // table of vectors: mixed values with gaps (R2, R3)
        cur_tag = "R2/R3 vector";
        foreach (VEC[v]) begin
            if (VEC[v][16]) send(VEC[v][15:0]);
            else            idle(1);
        end
        idle(8);
        check(head == tail, "R2 all outputs seen", head, tail);
        // R7: output holds after last strobe
        check($signed(out_data) == last_exp, "R7 hold", $signed(out_data), last_exp);
        check(ready_miss == 0, "R6 full rate", ready_miss, 0);

        // impulse: odd taps appear, exercising half-LSB rounding (R3, R8)
        do_reset();
        cur_tag = "R3/R8 impulse";
        send(16'd16384);
        for (int i = 0; i < 19; i++) send(16'd0);
        idle(8);
        check(head == tail, "R3 impulse outputs seen", head, tail);

        // positive clipping (R5)
        do_reset();
        cur_tag = "R5 positive clip";
        for (int i = 0; i < 20; i++) send(16'h7FFF);
        idle(6);
        check($signed(out_data) == 32767, "R5 positive clip final", $signed(out_data), 32767);

        // negative clipping (R5)
        do_reset();
        cur_tag = "R5 negative clip";
        for (int i = 0; i < 20; i++) send(16'h8000);
        idle(6);
        check($signed(out_data) == -32768, "R5 negative clip final", $signed(out_data), -32768);

        // alternating full scale with stalls: lone samples between gaps (R2)
        do_reset();
        cur_tag = "R2 sparse";
        for (int i = 0; i < 12; i++) begin
            send((i % 2 == 0) ? 16'h4000 : 16'hC000);
            idle(i % 3);
        end
        idle(8);
        check(head == tail, "R2 sparse outputs seen", head, tail);
        check(ready_miss == 0, "R6 full rate overall", ready_miss, 0);

        // reset during a computation discards it (R1)
        do_reset();
        send(16'd1000);
        send(16'd2000);
        @(negedge clk);
        rst = 1'b1;
        in_valid = 1'b0;
        head = tail;
        @(negedge clk);
        check(out_valid == 1'b0, "R1 no strobe in reset", out_valid, 0);
        check(out_data == 16'd0, "R1 data cleared", out_data, 0);
        rst = 1'b0;
        for (int i = 0; i < 16; i++) hist[i] = 0;
        ph = 0;
        @(negedge clk);
        check(out_valid == 1'b0, "R1 no strobe after reset", out_valid, 0);
        check(in_ready == 1'b1, "R1 ready after reset", in_ready, 1);
        idle(4);
        check(out_data == 16'd0, "R1 aborted result dropped", out_data, 0);

        done = 1;
        summary();
        $finish;
    end
endmodule